// File: doc/BRIEF.md
# Parity-Protected Word RAM with Error Capture

This block wraps a small single-port on-chip RAM. Every stored word holds a data field of 15 bits and one parity bit beside it. The parity bit is generated when the word is written and checked when it is read back. When a check fails, the block raises a sticky error flag and records the word index of the first failing location in a capture register. It also drives a one-cycle error strobe together with the read data.

Software reaches the block through a simple word-addressed request bus. In functional mode the parity bits cannot be addressed. When the test-mode input is high, the parity bits appear in a separate window at word offset 0xA00, one entry for each data word. Software can read them and overwrite them there, so a later functional read fails on purpose and exercises the self-test path.

A debug-freeze input keeps the capture register unchanged while a debugger reads it. Outside freeze, reading the capture register returns its value and clears it.

Top module: `parity_ram`

## Requirements
- R1: A write to the data window (word offsets 0 to DEPTH-1) stores `wdata_i[14:0]` as the data field and an odd parity bit as bit 15, set so the 16-bit word has an odd number of ones. A zero data word therefore reads back as 0x8000, and a data value of 1 reads back as 0x0001.
- R2: Every read request gives `rvalid_o` high on the following cycle, with `rdata_o` valid in that same cycle. Unmapped addresses read as 0.
- R3: When a data-window read finds a word with an even number of ones and checking is enabled, `par_err_o` is high in the same cycle as `rvalid_o`, and status bit 0 (error flag) becomes 1.
- R4: The capture register at word offset 0xF01 holds bit 15 = valid and bits 5:0 = the failing word index. A new error is recorded only while the register is not valid, so the first error is kept.
- R5: With `freeze_i` low, a read of the capture register returns its current value and clears it to 0.
- R6: With `freeze_i` high, reading the capture register leaves its value unchanged.
- R7: The status register at word offset 0xF00 has bit 0 = error flag, which is cleared by writing 1. Writing 0 to bit 0 has no effect on the flag.
- R8: Status bit 1 is the check enable and resets to 1. While it is 0, a bad word raises no `par_err_o`, does not set the flag and is not captured.
- R9: With `test_mode_i` high, a read at word offset 0xA00+i returns the parity bit of word i in bit 0. A write there replaces only that parity bit with `wdata_i[0]` and leaves the data field unchanged.
- R10: With `test_mode_i` low, the parity window reads as 0, and writes to it change nothing.
- R11: After reset, status reads 0x0002 and the capture register reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 12 | Word address |
| wdata_i | input | 16 | Write data |
| test_mode_i | input | 1 | Opens the parity window |
| freeze_i | input | 1 | Debug freeze of the capture register |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 16 | Read data |
| par_err_o | output | 1 | Parity error strobe, aligned with read data |

## Verification
The bench writes every word with computed data and reads each one back through both windows. A wrong parity sense would turn the 0x8000 and 0x0001 cases into false errors. It corrupts two words, and a capture register that kept the latest error instead of the first would report index 9 instead of 7. It reads the capture register under freeze, where a clear that ignores freeze loses the address, and again without freeze, where a missing clear leaves a stale value. It also writes the parity window with test mode off, with checking disabled, and with a zero in the flag's clear bit. A decoder that ignored test mode, an enable that did not gate capture, or a flag cleared by any write would each change a value the bench reads back.

// File: rtl/parity_ram_pkg.sv
package parity_ram_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PAR  = 2'd2,
    SEL_REG  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/parity_ram_store.sv
module parity_ram_store #(
  parameter int DATA_W = 15,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_data_i,
  input  logic              wr_par_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wpar_i,
  output logic [DATA_W:0]   word_o,
  output logic              mismatch_o
);
  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i) begin
    if (wr_data_i)     mem_q[idx_i] <= {~^wdata_i, wdata_i};
    else if (wr_par_i) mem_q[idx_i][WORD_W-1] <= wpar_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (rd_i) word_q <= mem_q[idx_i];
  end

  assign word_o     = word_q;
  // odd parity: a good word has an odd number of ones
  assign mismatch_o = ~(^word_q);

  // R1
  odd_parity_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> (^mem_q[$past(idx_i)]) == 1'b1);

  // R9
  par_wr_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_par_i && !wr_data_i) |=>
      mem_q[$past(idx_i)][DATA_W-1:0] == $past(mem_q[idx_i][DATA_W-1:0]));
endmodule

// File: rtl/parity_ram_regs.sv
module parity_ram_regs #(
  parameter int IDX_W  = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic [IDX_W-1:0]  err_idx_i,
  input  logic              stat_we_i,
  input  logic [1:0]        stat_wdata_i,
  input  logic              cap_rd_i,
  input  logic              freeze_i,
  output logic              chk_en_o,
  output logic              err_flag_o,
  output logic [WORD_W-1:0] cap_o
);
  logic             chk_en_q, err_flag_q, cap_vld_q;
  logic [IDX_W-1:0] cap_idx_q;
  logic             cap_clr, cap_keep;

  assign cap_clr  = cap_rd_i && !freeze_i;
  assign cap_keep = cap_vld_q && !cap_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_en_q   <= 1'b1;
      err_flag_q <= 1'b0;
    end else begin
      if (stat_we_i) chk_en_q <= stat_wdata_i[1];
      if (err_i)                            err_flag_q <= 1'b1;
      else if (stat_we_i && stat_wdata_i[0]) err_flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else if (err_i && !cap_keep) begin
      cap_vld_q <= 1'b1;
      cap_idx_q <= err_idx_i;
    end else if (cap_clr) begin
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end
  end

  assign chk_en_o   = chk_en_q;
  assign err_flag_o = err_flag_q;
  assign cap_o      = {cap_vld_q, {(WORD_W-1-IDX_W){1'b0}}, cap_idx_q};

  // R3
  err_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_flag_q);

  // R4
  first_err_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_vld_q && !cap_clr) |=> (cap_vld_q && $stable(cap_idx_q)));

  // R6
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && cap_vld_q) |=> cap_vld_q);

  // R5
  cap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_clr && !err_i) |=> (cap_o == '0));
endmodule

// File: rtl/parity_ram.sv
module parity_ram
  import parity_ram_pkg::*;
#(
  parameter int          DATA_W    = 15,
  parameter int          DEPTH     = 64,
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] PAR_BASE  = 12'hA00,
  parameter logic [11:0] STAT_ADDR = 12'hF00,
  parameter logic [11:0] CAP_ADDR  = 12'hF01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W:0]   wdata_i,
  input  logic              test_mode_i,
  input  logic              freeze_i,
  output logic              rvalid_o,
  output logic [DATA_W:0]   rdata_o,
  output logic              par_err_o
);
  localparam int WORD_W = DATA_W + 1;
  localparam int IDX_W  = $clog2(DEPTH);

  logic              in_data, in_par, is_stat, is_cap, rd, wr;
  logic [IDX_W-1:0]  idx, idx_q;
  logic [WORD_W-1:0] word, reg_q, stat_val, cap_val;
  logic              mismatch, chk_en, err_flag, err;
  logic              rvalid_q;
  rd_sel_e           sel_q;

  assign rd      = req_i && !we_i;
  assign wr      = req_i && we_i;
  assign in_data = addr_i < ADDR_W'(DEPTH);
  assign in_par  = test_mode_i && (addr_i >= ADDR_W'(PAR_BASE))
                   && (addr_i < ADDR_W'(PAR_BASE) + ADDR_W'(DEPTH));
  assign is_stat = addr_i == ADDR_W'(STAT_ADDR);
  assign is_cap  = addr_i == ADDR_W'(CAP_ADDR);
  assign idx     = in_par ? IDX_W'(addr_i - ADDR_W'(PAR_BASE)) : addr_i[IDX_W-1:0];

  parity_ram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (idx),
    .wr_data_i  (wr && in_data),
    .wr_par_i   (wr && in_par),
    .rd_i       (rd && (in_data || in_par)),
    .wdata_i    (wdata_i[DATA_W-1:0]),
    .wpar_i     (wdata_i[0]),
    .word_o     (word),
    .mismatch_o (mismatch)
  );

  assign err = rvalid_q && (sel_q == SEL_DATA) && mismatch && chk_en;

  parity_ram_regs #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .err_i        (err),
    .err_idx_i    (idx_q),
    .stat_we_i    (wr && is_stat),
    .stat_wdata_i (wdata_i[1:0]),
    .cap_rd_i     (rd && is_cap),
    .freeze_i     (freeze_i),
    .chk_en_o     (chk_en),
    .err_flag_o   (err_flag),
    .cap_o        (cap_val)
  );

  assign stat_val = {{(WORD_W-2){1'b0}}, chk_en, err_flag};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      sel_q    <= SEL_NONE;
      reg_q    <= '0;
      idx_q    <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) begin
        idx_q <= idx;
        reg_q <= is_stat ? stat_val : cap_val;
        if (in_data)                sel_q <= SEL_DATA;
        else if (in_par)            sel_q <= SEL_PAR;
        else if (is_stat || is_cap) sel_q <= SEL_REG;
        else                        sel_q <= SEL_NONE;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rvalid_q) begin
      unique case (sel_q)
        SEL_DATA: rdata_o = word;
        SEL_PAR:  rdata_o = {{(WORD_W-1){1'b0}}, word[WORD_W-1]};
        SEL_REG:  rdata_o = reg_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign rvalid_o  = rvalid_q;
  assign par_err_o = err;

  // R3
  perr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> rvalid_o);

  // R2
  rvalid_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
endmodule

// File: tb/sim_parity_ram.sv
module sim_parity_ram;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        test_mode_i = 1'b0;
  logic        freeze_i = 1'b0;
  logic        rvalid_o;
  logic [15:0] rdata_o;
  logic        par_err_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] rd_val;
  logic        rd_perr, rd_vld;

  always #10 clk_i = ~clk_i;

  parity_ram u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .test_mode_i(test_mode_i),
    .freeze_i(freeze_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .par_err_o(par_err_o)
  );

  function automatic logic [14:0] dval(int i);
    if (i == 0) return 15'h0000;
    if (i == 1) return 15'h0001;
    return 15'((i * 421) ^ (i << 9));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    rd_val = rdata_o; rd_perr = par_err_o; rd_vld = rvalid_o;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 reset state
    bus_rd(12'hF00); check("R11 status", rd_val, 16'h0002);
    bus_rd(12'hF01); check("R11 capture", rd_val, 16'h0000);

    // R1 fill every word
    for (int i = 0; i < 64; i++) bus_wr(12'(i), {1'b0, dval(i)});

    // R1 R2 read back
    for (int i = 0; i < 64; i++) begin
      bus_rd(12'(i));
      check("R2 rvalid", rd_vld, 1);
      check("R1 word", rd_val, {~^dval(i), dval(i)});
      check("R3 no error on good word", rd_perr, 0);
    end
    bus_rd(12'd0); check("R1 zero reads 0x8000", rd_val, 16'h8000);
    bus_rd(12'd1); check("R1 one reads 0x0001", rd_val, 16'h0001);
    bus_rd(12'h500); check("R2 unmapped reads 0", rd_val, 0);

    // R10 parity window closed
    bus_rd(12'hA05); check("R10 window read 0", rd_val, 0);
    bus_wr(12'hA05, {15'd0, ~(~^dval(5))});
    bus_rd(12'd5);
    check("R10 word unchanged", rd_val, {~^dval(5), dval(5)});
    check("R10 no error", rd_perr, 0);

    // R9 parity window open
    test_mode_i = 1'b1;
    for (int i = 0; i < 64; i++) begin
      bus_rd(12'hA00 + 12'(i));
      check("R9 parity read", rd_val, {15'd0, ~^dval(i)});
    end
    bus_wr(12'hA07, {15'd0, ~(~^dval(7))});
    bus_wr(12'hA09, {15'd0, ~(~^dval(9))});
    test_mode_i = 1'b0;

    // R3 R9 injected error
    bus_rd(12'd7);
    check("R9 data kept", rd_val[14:0], dval(7));
    check("R3 perr strobe", rd_perr, 1);
    bus_rd(12'hF00); check("R3 flag set", rd_val, 16'h0003);
    bus_rd(12'd9); check("R3 second error", rd_perr, 1);

    // R6 freeze keeps capture
    freeze_i = 1'b1;
    bus_rd(12'hF01); check("R4 first error kept", rd_val, 16'h8007);
    bus_rd(12'hF01); check("R6 frozen", rd_val, 16'h8007);
    freeze_i = 1'b0;

    // R5 clear on read
    bus_rd(12'hF01); check("R5 read value", rd_val, 16'h8007);
    bus_rd(12'hF01); check("R5 cleared", rd_val, 16'h0000);
    bus_rd(12'd9);
    bus_rd(12'hF01); check("R4 new capture", rd_val, 16'h8009);

    // R7 write-1-to-clear
    bus_wr(12'hF00, 16'h0002);
    bus_rd(12'hF00); check("R7 write 0 no effect", rd_val, 16'h0003);
    bus_wr(12'hF00, 16'h0003);
    bus_rd(12'hF00); check("R7 cleared", rd_val, 16'h0002);

    // R8 checking disabled
    bus_wr(12'hF00, 16'h0000);
    bus_rd(12'd9); check("R8 no strobe", rd_perr, 0);
    bus_rd(12'hF00); check("R8 no flag", rd_val, 16'h0000);
    bus_rd(12'hF01); check("R8 no capture", rd_val, 16'h0000);
    bus_wr(12'hF00, 16'h0002);

    // R9 repair word 7
    test_mode_i = 1'b1;
    bus_wr(12'hA07, {15'd0, ~^dval(7)});
    test_mode_i = 1'b0;
    bus_rd(12'd7);
    check("R9 repaired word", rd_val, {~^dval(7), dval(7)});
    check("R9 repaired no error", rd_perr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule